// File: doc/BRIEF.md
# Compressed instruction expander

This block sits between instruction fetch and decode. It looks at the low half of each fetched 32-bit word. If the two lowest bits are not both set, the half is a 16-bit compressed instruction. The block rewrites it into the one 32-bit base integer instruction that does the same thing. Words whose low bits are both set are already full-width instructions and pass through unchanged.

Compressed forms scatter their immediate bits across the halfword and scale them by 2, 4 or 16. Several forms reuse the same opcode slot and are told apart by which register field is zero. The expander puts the immediate bits back in order, maps the 3-bit short register fields onto x8..x15, and flags as illegal any encoding that breaks a register or immediate restriction.

By default the result is registered, so it appears one cycle after the input. A parameter selects a purely combinational variant instead. Floating-point compressed forms and the alignment of instructions within fetch words are outside this block.

Top module: `cinstr_expander`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is cleared to zero after that edge, whatever the inputs are.
- R2: Each output shows the result for the input sampled at the previous rising edge. `exp_valid_o` follows `fetch_valid_i` with that delay. For an input with `fetch_valid_i` low, `exp_word_o`, `was_compressed_o` and `illegal_o` are zero.
- R3: When input bits [1:0] are 2'b11, `exp_word_o` equals the whole input word, and `was_compressed_o` and `illegal_o` are low.
- R4: A 3-bit short register field with value n names register x(8+n) in the expanded instruction.
- R5: Quadrant 0, funct3 000 (bits [15:13]) becomes `addi rd', x2, imm`. The immediate is unsigned, scaled by 4 and must be nonzero. A zero immediate, which includes the all-zero halfword, is illegal.
- R6: The quadrant 0 short word load (funct3 010) and short word store (funct3 110) use a 5-bit unsigned offset scaled by 4 from a short base register.
- R7: Quadrant 1, funct3 011, with destination x2 adds a nonzero signed 6-bit immediate scaled by 16 to x2. With any other destination it becomes `lui`: the 6-bit value goes into bits 17:12, is sign-extended above them, and the bits below are zero. A zero immediate, or a `lui` destination of x0, is illegal.
- R8: Quadrant 1, funct3 001, jumps by a signed 11-bit offset in units of 2 and writes the return address to x1. Funct3 101 does the same jump and writes x0.
- R9: Quadrant 1, funct3 110 and 111, branch if a short register is equal (110) or not equal (111) to x0. The offset is a signed 8-bit value in units of 2.
- R10: Quadrant 2, funct3 100, selects between forms. With bit 12 low: if rs2 is zero it is a register jump (`jalr x0`), otherwise a move (`add rd, x0, rs2`). With bit 12 high: if rs2 is zero it is a register jump-and-link (`jalr x1`), otherwise `add rd, rd, rs2`. The two register jumps are illegal with rs1 = x0. Bit 12 high with both fields zero gives `ebreak` (32'h00100073).
- R11: Quadrant 2 stack-relative word load (funct3 010) and store (funct3 110) use a 6-bit unsigned offset scaled by 4 from x2. The load is illegal with destination x0.
- R12: The immediate shifts are quadrant 1 funct3 100 with bits [11:10] = 00 for the logical right shift and 01 for the arithmetic right shift, and quadrant 2 funct3 000 for the left shift. These shifts, and the register-register group (quadrant 1 funct3 100, bits [11:10] = 11: [6:5] 00 sub, 01 xor, 10 or, 11 and), are illegal when bit 12 is set. The AND-immediate form uses bits [11:10] = 10.
- R13: Quadrant 0 funct3 001, 011, 100, 101 and 111, and quadrant 2 funct3 001, 011, 101 and 111, are illegal. An illegal result sets `was_compressed_o`, and `exp_word_o` holds the raw halfword zero-extended. Input bits [31:16] have no effect on a compressed result.
- R14: Quadrant 1 funct3 000 (`addi rd, rd, imm`) and funct3 010 (`addi rd, x0, imm`) sign-extend a 6-bit immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_word_i | input | 32 | Fetched word; the low half is examined first |
| fetch_valid_i | input | 1 | Fetch word is meaningful |
| exp_word_o | output | 32 | Expanded or passed-through instruction |
| exp_valid_o | output | 1 | Result is meaningful |
| was_compressed_o | output | 1 | Input was a 16-bit form |
| illegal_o | output | 1 | Compressed input broke an encoding restriction |

## Verification
Two functions can meet in one cycle: reset and a valid fetch word that arrives while reset is held. The bench drives valid compressed words during reset and requires the outputs to stay zero.

The second meeting point is between back-to-back inputs of different kinds. Pass-through words, compressed words and illegal words arrive on consecutive cycles, so the compressed flag and the illegal flag change state on every edge. The bench compares each cycle against a behavioural model that builds the immediates by field position and places the bits by arithmetic. Any flag or word that lags, leaks or sticks is reported against its requirement.

// File: rtl/cexp_pkg.sv
// Package cexp_pkg
// Shared widths, base opcodes and 32-bit encoders for the compressed
// instruction expander. Assumes the 32-bit base integer instruction set.
package cexp_pkg;

    localparam int unsigned ILEN = 32;
    localparam int unsigned CLEN = 16;
    localparam int unsigned RIDX = 5;
    localparam int unsigned SIDX = 3;

    localparam logic [6:0] OPC_LOAD   = 7'h03;
    localparam logic [6:0] OPC_OPIMM  = 7'h13;
    localparam logic [6:0] OPC_STORE  = 7'h23;
    localparam logic [6:0] OPC_OP     = 7'h33;
    localparam logic [6:0] OPC_LUI    = 7'h37;
    localparam logic [6:0] OPC_BRANCH = 7'h63;
    localparam logic [6:0] OPC_JALR   = 7'h67;
    localparam logic [6:0] OPC_JAL    = 7'h6F;

    localparam logic [ILEN-1:0] WORD_EBREAK = 32'h0010_0073;

    localparam logic [RIDX-1:0] REG_ZERO = 5'd0;
    localparam logic [RIDX-1:0] REG_RA   = 5'd1;
    localparam logic [RIDX-1:0] REG_SP   = 5'd2;

    // Result of one quadrant decoder: the expanded word and an illegal mark.
    typedef struct packed {
        logic [ILEN-1:0] word;
        logic            bad;
    } exp_res_t;

    // Short register field n names x(8+n).
    function automatic logic [RIDX-1:0] widen(input logic [SIDX-1:0] r);
        return {2'b01, r};
    endfunction

    function automatic logic [ILEN-1:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                              input logic [2:0] f3, input logic [4:0] rd,
                                              input logic [6:0] opc);
        return {imm, rs1, f3, rd, opc};
    endfunction

    function automatic logic [ILEN-1:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                              input logic [4:0] rs1, input logic [2:0] f3,
                                              input logic [6:0] opc);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
    endfunction

    function automatic logic [ILEN-1:0] enc_b(input logic [12:1] off, input logic [4:0] rs2,
                                              input logic [4:0] rs1, input logic [2:0] f3);
        return {off[12], off[10:5], rs2, rs1, f3, off[4:1], off[11], OPC_BRANCH};
    endfunction

    function automatic logic [ILEN-1:0] enc_u(input logic [19:0] imm, input logic [4:0] rd,
                                              input logic [6:0] opc);
        return {imm, rd, opc};
    endfunction

    function automatic logic [ILEN-1:0] enc_j(input logic [20:1] off, input logic [4:0] rd);
        return {off[20], off[10:1], off[11], off[19:12], rd, OPC_JAL};
    endfunction

    function automatic logic [ILEN-1:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                              input logic [4:0] rs1, input logic [2:0] f3,
                                              input logic [4:0] rd, input logic [6:0] opc);
        return {f7, rs2, rs1, f3, rd, opc};
    endfunction

endpackage

// File: rtl/cexp_quad0.sv
// Module cexp_quad0
// Expands quadrant 0 halfwords: stack-pointer address add, short word load
// and short word store. Every other funct3 slot is marked illegal.
// Assumes the caller has already checked that bits [1:0] are 2'b00.
module cexp_quad0
    import cexp_pkg::*;
(
    input  logic [CLEN-1:2] half,
    output exp_res_t        res
);

    logic [RIDX-1:0] rd_s;
    logic [RIDX-1:0] base_s;
    logic [9:0]      spn_imm;
    logic [6:0]      word_off;

    assign rd_s     = widen(half[4:2]);
    assign base_s   = widen(half[9:7]);
    assign spn_imm  = {half[10:7], half[12:11], half[5], half[6], 2'b00};
    assign word_off = {half[5], half[12:10], half[6], 2'b00};

    // Select the expansion for the funct3 slot.
    always_comb begin
        res.word = '0;
        res.bad  = 1'b0;
        case (half[15:13])
            3'b000: begin
                res.word = enc_i({2'b00, spn_imm}, REG_SP, 3'b000, rd_s, OPC_OPIMM);
                res.bad  = (spn_imm == '0);
            end
            3'b010: res.word = enc_i({5'b0, word_off}, base_s, 3'b010, rd_s, OPC_LOAD);
            3'b110: res.word = enc_s({5'b0, word_off}, rd_s, base_s, 3'b010, OPC_STORE);
            default: res.bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/cexp_quad1.sv
// Module cexp_quad1
// Expands quadrant 1 halfwords: immediate add and load, jumps, stack adjust,
// upper immediate, short-register ALU group and branches against zero.
// Assumes the caller has already checked that bits [1:0] are 2'b01.
module cexp_quad1
    import cexp_pkg::*;
(
    input  logic [CLEN-1:2] half,
    output exp_res_t        res
);

    logic [RIDX-1:0] rd_f;
    logic [RIDX-1:0] rs1_s;
    logic [RIDX-1:0] rs2_s;
    logic [5:0]      imm6;
    logic [11:0]     imm6_sx;
    logic [11:1]     jmp_off;
    logic [20:1]     jmp_sx;
    logic [8:1]      br_off;
    logic [12:1]     br_sx;
    logic [9:4]      sp16;
    logic [11:0]     sp16_sx;
    logic [19:0]     lui_sx;
    logic [6:0]      alu_f7;
    logic [2:0]      alu_f3;

    assign rd_f    = half[11:7];
    assign rs1_s   = widen(half[9:7]);
    assign rs2_s   = widen(half[4:2]);
    assign imm6    = {half[12], half[6:2]};
    assign imm6_sx = {{6{half[12]}}, imm6};
    assign jmp_off = {half[12], half[8], half[10:9], half[6], half[7], half[2], half[11], half[5:3]};
    assign jmp_sx  = {{9{half[12]}}, jmp_off};
    assign br_off  = {half[12], half[6:5], half[2], half[11:10], half[4:3]};
    assign br_sx   = {{4{half[12]}}, br_off};
    assign sp16    = {half[12], half[4:3], half[5], half[2], half[6]};
    assign sp16_sx = {{2{half[12]}}, sp16, 4'b0000};
    assign lui_sx  = {{14{half[12]}}, imm6};

    // Map the two-bit ALU selector to base funct7 / funct3.
    always_comb begin
        alu_f7 = 7'b0000000;
        case (half[6:5])
            2'b00:   begin alu_f3 = 3'b000; alu_f7 = 7'b0100000; end
            2'b01:   alu_f3 = 3'b100;
            2'b10:   alu_f3 = 3'b110;
            default: alu_f3 = 3'b111;
        endcase
    end

    // Select the expansion for the funct3 slot.
    always_comb begin
        res.word = '0;
        res.bad  = 1'b0;
        case (half[15:13])
            3'b000: res.word = enc_i(imm6_sx, rd_f, 3'b000, rd_f, OPC_OPIMM);
            3'b001: res.word = enc_j(jmp_sx, REG_RA);
            3'b010: res.word = enc_i(imm6_sx, REG_ZERO, 3'b000, rd_f, OPC_OPIMM);
            3'b011: begin
                if (rd_f == REG_SP) begin
                    res.word = enc_i(sp16_sx, REG_SP, 3'b000, REG_SP, OPC_OPIMM);
                    res.bad  = (imm6 == '0);
                end else begin
                    res.word = enc_u(lui_sx, rd_f, OPC_LUI);
                    res.bad  = (imm6 == '0) || (rd_f == REG_ZERO);
                end
            end
            3'b100: begin
                case (half[11:10])
                    2'b00: begin
                        res.word = enc_i({7'b0000000, half[6:2]}, rs1_s, 3'b101, rs1_s, OPC_OPIMM);
                        res.bad  = half[12];
                    end
                    2'b01: begin
                        res.word = enc_i({7'b0100000, half[6:2]}, rs1_s, 3'b101, rs1_s, OPC_OPIMM);
                        res.bad  = half[12];
                    end
                    2'b10: res.word = enc_i(imm6_sx, rs1_s, 3'b111, rs1_s, OPC_OPIMM);
                    default: begin
                        res.word = enc_r(alu_f7, rs2_s, rs1_s, alu_f3, rs1_s, OPC_OP);
                        res.bad  = half[12];
                    end
                endcase
            end
            3'b101: res.word = enc_j(jmp_sx, REG_ZERO);
            default: res.word = enc_b(br_sx, REG_ZERO, rs1_s, {2'b00, half[13]});
        endcase
    end

endmodule

// File: rtl/cexp_quad2.sv
// Module cexp_quad2
// Expands quadrant 2 halfwords: left shift, stack-relative load and store,
// and the register jump / move / add / breakpoint group.
// Assumes the caller has already checked that bits [1:0] are 2'b10.
module cexp_quad2
    import cexp_pkg::*;
(
    input  logic [CLEN-1:2] half,
    output exp_res_t        res
);

    logic [RIDX-1:0] rd_f;
    logic [RIDX-1:0] rs2_f;
    logic [7:2]      ld_off;
    logic [7:2]      st_off;

    assign rd_f   = half[11:7];
    assign rs2_f  = half[6:2];
    assign ld_off = {half[3:2], half[12], half[6:4]};
    assign st_off = {half[8:7], half[12:9]};

    // Select the expansion for the funct3 slot.
    always_comb begin
        res.word = '0;
        res.bad  = 1'b0;
        case (half[15:13])
            3'b000: begin
                res.word = enc_i({7'b0000000, half[6:2]}, rd_f, 3'b001, rd_f, OPC_OPIMM);
                res.bad  = half[12];
            end
            3'b010: begin
                res.word = enc_i({4'b0, ld_off, 2'b00}, REG_SP, 3'b010, rd_f, OPC_LOAD);
                res.bad  = (rd_f == REG_ZERO);
            end
            3'b100: begin
                if (!half[12]) begin
                    if (rs2_f == REG_ZERO) begin
                        res.word = enc_i(12'h000, rd_f, 3'b000, REG_ZERO, OPC_JALR);
                        res.bad  = (rd_f == REG_ZERO);
                    end else begin
                        res.word = enc_r(7'b0, rs2_f, REG_ZERO, 3'b000, rd_f, OPC_OP);
                    end
                end else if (rs2_f == REG_ZERO) begin
                    if (rd_f == REG_ZERO) begin
                        res.word = WORD_EBREAK;
                    end else begin
                        res.word = enc_i(12'h000, rd_f, 3'b000, REG_RA, OPC_JALR);
                    end
                end else begin
                    res.word = enc_r(7'b0, rs2_f, rd_f, 3'b000, rd_f, OPC_OP);
                end
            end
            3'b110: res.word = enc_s({4'b0, st_off, 2'b00}, rs2_f, REG_SP, 3'b010, OPC_STORE);
            default: res.bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/cinstr_expander.sv
// Module cinstr_expander (top)
// Turns a fetched word into a 32-bit base instruction. A low half with
// bits [1:0] != 2'b11 is expanded by one of three quadrant decoders;
// otherwise the full word passes through. Illegal compressed encodings
// return the raw halfword zero-extended with illegal_o set.
// Assumes the instruction sits in bits [15:0] of the fetch word.
// REG_OUT = 1 registers the outputs (one cycle latency, synchronous
// active-low reset); REG_OUT = 0 leaves the block combinational.
module cinstr_expander
    import cexp_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ILEN-1:0] fetch_word_i,
    input  logic            fetch_valid_i,
    output logic [ILEN-1:0] exp_word_o,
    output logic            exp_valid_o,
    output logic            was_compressed_o,
    output logic            illegal_o
);

    logic [CLEN-1:0] half;
    exp_res_t        res_q0;
    exp_res_t        res_q1;
    exp_res_t        res_q2;
    exp_res_t        res_sel;
    logic [ILEN-1:0] nxt_word;
    logic            nxt_comp;
    logic            nxt_bad;

    assign half = fetch_word_i[CLEN-1:0];

    cexp_quad0 u_q0 (.half(half[CLEN-1:2]), .res(res_q0));
    cexp_quad1 u_q1 (.half(half[CLEN-1:2]), .res(res_q1));
    cexp_quad2 u_q2 (.half(half[CLEN-1:2]), .res(res_q2));

    // Pick the quadrant decoder named by bits [1:0].
    always_comb begin
        case (half[1:0])
            2'b00:   res_sel = res_q0;
            2'b01:   res_sel = res_q1;
            2'b10:   res_sel = res_q2;
            default: res_sel = '{word: fetch_word_i, bad: 1'b0};
        endcase
    end

    // Form the next outputs, quieted when the input is not valid.
    always_comb begin
        nxt_word = '0;
        nxt_comp = 1'b0;
        nxt_bad  = 1'b0;
        if (fetch_valid_i) begin
            nxt_comp = (half[1:0] != 2'b11);
            nxt_bad  = nxt_comp && res_sel.bad;
            nxt_word = nxt_bad ? {{(ILEN-CLEN){1'b0}}, half} : res_sel.word;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            // Output register with synchronous active-low reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    exp_word_o       <= '0;
                    exp_valid_o      <= 1'b0;
                    was_compressed_o <= 1'b0;
                    illegal_o        <= 1'b0;
                end else begin
                    exp_word_o       <= nxt_word;
                    exp_valid_o      <= fetch_valid_i;
                    was_compressed_o <= nxt_comp;
                    illegal_o        <= nxt_bad;
                end
            end
        end else begin : g_comb
            assign exp_word_o       = nxt_word;
            assign exp_valid_o      = fetch_valid_i;
            assign was_compressed_o = nxt_comp;
            assign illegal_o        = nxt_bad;
        end
    endgenerate

endmodule

// File: rtl/cinstr_expander_chk.sv
// Module cinstr_expander_chk
// Property checker bound to cinstr_expander. Watches only the ports.
// The timed properties apply to the registered variant.
module cinstr_expander_chk
    import cexp_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ILEN-1:0] fetch_word_i,
    input logic            fetch_valid_i,
    input logic [ILEN-1:0] exp_word_o,
    input logic            exp_valid_o,
    input logic            was_compressed_o,
    input logic            illegal_o
);

    // R13: illegal is only reported for compressed inputs
    a_r13_illegal_only_compressed: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> was_compressed_o);

    // R13: illegal result carries the zero-extended raw halfword
    a_r13_illegal_raw_half: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (exp_word_o[31:16] == 16'h0 && exp_word_o[1:0] != 2'b11));

    // R2: an idle slot carries no flags and no word
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !exp_valid_o |-> (!was_compressed_o && !illegal_o && exp_word_o == '0));

    // R13: a legal expansion is always a full-width instruction
    a_r13_legal_full_width: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_valid_o && was_compressed_o && !illegal_o) |-> (exp_word_o[1:0] == 2'b11));

    generate
        if (REG_OUT) begin : g_timed
            logic armed;

            // Marks cycles whose previous edge was already out of reset.
            always_ff @(posedge clk) begin
                if (!rst_n) armed <= 1'b0;
                else        armed <= 1'b1;
            end

            // R2: valid follows the input one cycle later
            a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
                armed |-> (exp_valid_o == $past(fetch_valid_i)));

            // R3: full-width words pass through unchanged
            a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
                (armed && $past(fetch_valid_i && fetch_word_i[1:0] == 2'b11))
                |-> (exp_word_o == $past(fetch_word_i) && !was_compressed_o && !illegal_o));

            // R5: the all-zero halfword is illegal
            a_r5_zero_half_illegal: assert property (@(posedge clk) disable iff (!rst_n)
                (armed && $past(fetch_valid_i && fetch_word_i[15:0] == 16'h0)) |-> illegal_o);
        end
    endgenerate

endmodule

bind cinstr_expander cinstr_expander_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .fetch_word_i     (fetch_word_i),
    .fetch_valid_i    (fetch_valid_i),
    .exp_word_o       (exp_word_o),
    .exp_valid_o      (exp_valid_o),
    .was_compressed_o (was_compressed_o),
    .illegal_o        (illegal_o)
);

// File: tb/cinstr_expander_tb.sv
`timescale 1ns/1ps
// Bench for cinstr_expander: behavioural reference model, one compare per clock.
module cinstr_expander_tb;

    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fetch_word_i;
    logic        fetch_valid_i;
    logic [31:0] exp_word_o;
    logic        exp_valid_o;
    logic        was_compressed_o;
    logic        illegal_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] word;
        logic        vld;
        logic        comp;
        logic        ill;
        string       tag;
        bit          lit_en;
        logic [31:0] lit_word;
        logic        lit_ill;
        string       lit_tag;
    } exp_t;

    exp_t pend_q[$];

    always #(CLK_NS/2.0) clk = ~clk;

    cinstr_expander u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_word_i(fetch_word_i), .fetch_valid_i(fetch_valid_i),
        .exp_word_o(exp_word_o), .exp_valid_o(exp_valid_o),
        .was_compressed_o(was_compressed_o), .illegal_o(illegal_o)
    );

    // ---------------- behavioural encoders ----------------
    function automatic logic [31:0] b_i(int imm, int rs1, int f3, int rd, int opc);
        return 32'(((imm & 'hfff) << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | opc);
    endfunction
    function automatic logic [31:0] b_s(int imm, int rs2, int rs1, int f3, int opc);
        return 32'((((imm >> 5) & 'h7f) << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12)
                   | ((imm & 'h1f) << 7) | opc);
    endfunction
    function automatic logic [31:0] b_b(int imm, int rs2, int rs1, int f3);
        return 32'((((imm >> 12) & 1) << 31) | (((imm >> 5) & 'h3f) << 25) | (rs2 << 20)
                   | (rs1 << 15) | (f3 << 12) | (((imm >> 1) & 'hf) << 8)
                   | (((imm >> 11) & 1) << 7) | 'h63);
    endfunction
    function automatic logic [31:0] b_j(int imm, int rd);
        return 32'((((imm >> 20) & 1) << 31) | (((imm >> 1) & 'h3ff) << 21)
                   | (((imm >> 11) & 1) << 20) | (((imm >> 12) & 'hff) << 12)
                   | (rd << 7) | 'h6f);
    endfunction
    function automatic logic [31:0] b_u(int imm, int rd, int opc);
        return 32'(((imm & 'hfffff) << 12) | (rd << 7) | opc);
    endfunction
    function automatic logic [31:0] b_r(int f7, int rs2, int rs1, int f3, int rd, int opc);
        return 32'((f7 << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | opc);
    endfunction
    function automatic int fld(logic [15:0] c, int lo, int n);
        return (int'(c) >> lo) & ((1 << n) - 1);
    endfunction

    // ---------------- reference model ----------------
    function automatic void ref_expand(input logic [31:0] w, output logic [31:0] e,
                                       output logic comp, output logic ill, output string tag);
        logic [15:0] c;
        int rd, rs2, rdp, rs1p, f3, imm, s6;
        c = w[15:0];
        e = '0; comp = 1'b1; ill = 1'b0; tag = "R13";
        if (c[1:0] == 2'b11) begin
            e = w; comp = 1'b0; tag = "R3";
            return;
        end
        rd   = fld(c, 7, 5);
        rs2  = fld(c, 2, 5);
        rdp  = 8 + fld(c, 2, 3);
        rs1p = 8 + fld(c, 7, 3);
        f3   = fld(c, 13, 3);
        s6   = (fld(c, 12, 1) << 5) | fld(c, 2, 5);
        if (s6 >= 32) s6 = s6 - 64;
        case (c[1:0])
            2'b00: begin
                if (f3 == 0) begin
                    tag = "R5 R4";
                    imm = (fld(c, 11, 2) << 4) | (fld(c, 7, 4) << 6) | (fld(c, 6, 1) << 2) | (fld(c, 5, 1) << 3);
                    if (imm == 0) ill = 1'b1; else e = b_i(imm, 2, 0, rdp, 'h13);
                end else if (f3 == 2 || f3 == 6) begin
                    tag = "R6 R4";
                    imm = (fld(c, 10, 3) << 3) | (fld(c, 6, 1) << 2) | (fld(c, 5, 1) << 6);
                    if (f3 == 2) e = b_i(imm, rs1p, 2, rdp, 'h03);
                    else         e = b_s(imm, rdp, rs1p, 2, 'h23);
                end else ill = 1'b1;
            end
            2'b01: begin
                case (f3)
                    0: begin tag = "R14"; e = b_i(s6, rd, 0, rd, 'h13); end
                    2: begin tag = "R14"; e = b_i(s6, 0, 0, rd, 'h13); end
                    1, 5: begin
                        tag = "R8";
                        imm = (fld(c, 12, 1) << 11) | (fld(c, 11, 1) << 4) | (fld(c, 9, 2) << 8)
                            | (fld(c, 8, 1) << 10) | (fld(c, 7, 1) << 6) | (fld(c, 6, 1) << 7)
                            | (fld(c, 3, 3) << 1) | (fld(c, 2, 1) << 5);
                        if (imm >= 2048) imm = imm - 4096;
                        e = b_j(imm, (f3 == 1) ? 1 : 0);
                    end
                    3: begin
                        tag = "R7";
                        if (rd == 2) begin
                            imm = (fld(c, 12, 1) << 9) | (fld(c, 6, 1) << 4) | (fld(c, 5, 1) << 6)
                                | (fld(c, 3, 2) << 7) | (fld(c, 2, 1) << 5);
                            if (imm >= 512) imm = imm - 1024;
                            if (imm == 0) ill = 1'b1; else e = b_i(imm, 2, 0, 2, 'h13);
                        end else if (rd == 0 || s6 == 0) ill = 1'b1;
                        else e = b_u(s6, rd, 'h37);
                    end
                    4: begin
                        tag = "R12 R4";
                        case (fld(c, 10, 2))
                            0: if (c[12]) ill = 1'b1; else e = b_i(rs2, rs1p, 5, rs1p, 'h13);
                            1: if (c[12]) ill = 1'b1; else e = b_i(rs2 + 1024, rs1p, 5, rs1p, 'h13);
                            2: e = b_i(s6, rs1p, 7, rs1p, 'h13);
                            default: begin
                                if (c[12]) ill = 1'b1;
                                else case (fld(c, 5, 2))
                                    0: e = b_r(32, rdp, rs1p, 0, rs1p, 'h33);
                                    1: e = b_r(0, rdp, rs1p, 4, rs1p, 'h33);
                                    2: e = b_r(0, rdp, rs1p, 6, rs1p, 'h33);
                                    default: e = b_r(0, rdp, rs1p, 7, rs1p, 'h33);
                                endcase
                            end
                        endcase
                    end
                    default: begin
                        tag = "R9";
                        imm = (fld(c, 12, 1) << 8) | (fld(c, 10, 2) << 3) | (fld(c, 5, 2) << 6)
                            | (fld(c, 3, 2) << 1) | (fld(c, 2, 1) << 5);
                        if (imm >= 256) imm = imm - 512;
                        e = b_b(imm, 0, rs1p, f3 - 6);
                    end
                endcase
            end
            default: begin
                case (f3)
                    0: begin tag = "R12"; if (c[12]) ill = 1'b1; else e = b_i(rs2, rd, 1, rd, 'h13); end
                    2: begin
                        tag = "R11";
                        imm = (fld(c, 12, 1) << 5) | (fld(c, 4, 3) << 2) | (fld(c, 2, 2) << 6);
                        if (rd == 0) ill = 1'b1; else e = b_i(imm, 2, 2, rd, 'h03);
                    end
                    4: begin
                        tag = "R10";
                        if (!c[12]) begin
                            if (rs2 == 0) begin
                                if (rd == 0) ill = 1'b1; else e = b_i(0, rd, 0, 0, 'h67);
                            end else e = b_r(0, rs2, 0, 0, rd, 'h33);
                        end else if (rs2 == 0) begin
                            if (rd == 0) e = 32'h0010_0073; else e = b_i(0, rd, 0, 1, 'h67);
                        end else e = b_r(0, rs2, rd, 0, rd, 'h33);
                    end
                    6: begin
                        tag = "R11";
                        imm = (fld(c, 9, 4) << 2) | (fld(c, 7, 2) << 6);
                        e = b_s(imm, rs2, 2, 2, 'h23);
                    end
                    default: ill = 1'b1;
                endcase
            end
        endcase
        if (ill) e = {16'h0, c};
    endfunction

    // ---------------- checking ----------------
    task automatic compare_pending();
        exp_t x;
        if (pend_q.size() == 0) return;
        x = pend_q.pop_front();
        total++;
        if (exp_word_o !== x.word || exp_valid_o !== x.vld ||
            was_compressed_o !== x.comp || illegal_o !== x.ill) begin
            bad++;
            $display("FAIL %s: actual word=%h vld=%b comp=%b ill=%b expected word=%h vld=%b comp=%b ill=%b",
                     x.tag, exp_word_o, exp_valid_o, was_compressed_o, illegal_o,
                     x.word, x.vld, x.comp, x.ill);
        end
        if (x.lit_en) begin
            total++;
            if (exp_word_o !== x.lit_word || illegal_o !== x.lit_ill) begin
                bad++;
                $display("FAIL %s: actual word=%h ill=%b expected word=%h ill=%b",
                         x.lit_tag, exp_word_o, illegal_o, x.lit_word, x.lit_ill);
            end
        end
    endtask

    // Drive one input at a falling edge; its result is judged one clock later.
    task automatic drive(input logic [31:0] w, input logic v, input bit lit_en,
                         input logic [31:0] lit_word, input logic lit_ill, input string lit_tag);
        exp_t x;
        @(negedge clk);
        compare_pending();
        fetch_word_i  = w;
        fetch_valid_i = v;
        ref_expand(w, x.word, x.comp, x.ill, x.tag);
        x.vld = v;
        if (!v) begin
            x.word = '0; x.comp = 1'b0; x.ill = 1'b0; x.tag = "R2";
        end
        x.lit_en = lit_en; x.lit_word = lit_word; x.lit_ill = lit_ill; x.lit_tag = lit_tag;
        pend_q.push_back(x);
    endtask

    task automatic lit(input logic [31:0] w, input logic [31:0] ew, input logic ei, input string t);
        drive(w, 1'b1, 1'b1, ew, ei, t);
    endtask

    // Main stimulus.
    initial begin
        logic [31:0] w;
        rst_n = 1'b0;
        fetch_valid_i = 1'b1;
        fetch_word_i  = 32'h0000_0001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (exp_word_o !== 32'h0 || exp_valid_o !== 1'b0 || was_compressed_o !== 1'b0 || illegal_o !== 1'b0) begin
            bad++;
            $display("FAIL R1: actual word=%h vld=%b comp=%b ill=%b expected all zero",
                     exp_word_o, exp_valid_o, was_compressed_o, illegal_o);
        end
        rst_n = 1'b1;

        lit(32'h0000_0000, 32'h0000_0000, 1'b1, "R5 zero halfword");
        lit(32'h0000_0001, 32'h0000_0013, 1'b0, "R14 nop");
        lit(32'h0000_9002, 32'h0010_0073, 1'b0, "R10 ebreak");
        lit(32'h0000_852E, 32'h00B0_0533, 1'b0, "R10 move");
        lit(32'h0000_8082, 32'h0000_8067, 1'b0, "R10 return jump");
        lit(32'h0000_8002, 32'h0000_8002, 1'b1, "R10 jump via x0");
        lit(32'h0000_557D, 32'hFFF0_0513, 1'b0, "R14 load -1");
        lit(32'h0000_4188, 32'h0005_A503, 1'b0, "R4 R6 short load");
        lit(32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, "R3 pass-through");
        lit(32'h0000_4002, 32'h0000_4002, 1'b1, "R11 load to x0");
        lit(32'hABCD_0001, 32'h0000_0013, 1'b0, "R13 upper bits ignored");
        drive(32'h0000_0001, 1'b0, 1'b0, '0, 1'b0, "");

        for (int i = 0; i < 6000; i++) begin
            w = $urandom;
            if ($urandom_range(3, 0) == 0) w[11:7] = 5'd0;
            if ($urandom_range(3, 0) == 0) w[6:2]  = 5'd0;
            if ($urandom_range(4, 0) == 0) w[12]   = 1'b0;
            if ($urandom_range(9, 0) == 0) w[11:7] = 5'd2;
            drive(w, ($urandom_range(7, 0) != 0), 1'b0, '0, 1'b0, "");
        end

        @(negedge clk);
        compare_pending();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_NS * 150000.0);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2: watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule